// File: doc/BRIEF.md
# Multichannel Converter Bus Control

This block is the device-side control logic for an 8-bit multichannel analog-to-digital converter. The converter is mapped on a processor bus like read-only memory. A bus read, meaning chip select and read both low, starts a conversion on the addressed input channel. The block does not perform the analog conversion. It sequences a separate conversion engine with two strobes: it sends a sample strobe at the end of the tracking window, and the engine returns a done strobe. The block builds the 8-bit result in two halves and presents it on a data bus with an output enable. It also drives an active-low ready line (drive-low or release) and an active-low interrupt.

The block has two bus modes, chosen by `pipeMode`.

- **Stalling mode (`pipeMode` = 0):** the ready line holds the processor until the fresh result is on the bus.
- **Pipelined mode (`pipeMode` = 1):** every read returns the result of the previous conversion at once and starts the next one. The channel address is captured when read rises.

All time windows are counted in system clock cycles:

- the tracking window;
- the point at which the upper half of the result is taken;
- the minimum spacing between accepted starts.

A read that arrives too early is rejected and reported on an error pulse.

Top module: `adc_bus_ctrl`

## Requirements
- R1: The 3-bit address selects the channel: code 0 to 7 gives channels 1 to 8, and `selChan` reports the code. In a 4-channel build, address bit 2 is ignored and `selChan[2]` stays 0. In stalling mode the address is taken at the start edge.
- R2: In stalling mode, `readyLow` is 1 from the cycle after chip select is sampled falling.
- R3: In stalling mode, `dataOe` stays 0 while the conversion runs. In the cycle after the edge where the engine's done strobe is seen, `readyLow` returns to 0, and `dataOe` goes to 1 with the result on `dataOut`, for as long as the read is held. At all other times `dataOut` is 0 when `dataOe` is 0.
- R4: `intN` goes to 0 in the cycle after done. It returns to 1 in the cycle after chip select or read rises at the end of an accepted read. Nothing else changes it.
- R5: In pipelined mode, the cycle after a read starts, `dataOe` is 1 and `dataOut` holds the last completed result. `readyLow` is never driven. The address is captured on the edge where read is sampled rising.
- R6: `sampleStrobe` is a single-cycle pulse. It is seen in the TRACK_CYC-th cycle after the start edge, counting the cycle after that edge as the first.
- R7: The result is natural binary. Bits 7:4 are taken from `engResult[7:4]` at the end of the COARSE_CYC-th cycle after the start. Bits 3:0 are taken from `engResult[3:0]` at done.
- R8: A read is rejected if it starts while a conversion is running or fewer than SPACE_CYC edges after the last accepted start. A start exactly SPACE_CYC edges later is accepted. A rejection raises `spacingErr` for one cycle, and the read causes no sample, no address capture, no change of result and no change of `intN`.
- R9: After reset, `intN` is 1, `readyLow` is 0, `dataOe` is 0, `spacingErr` is 0 and `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read |
| chanAddr | input | 3 | Channel address |
| pipeMode | input | 1 | 0 = stalling mode, 1 = pipelined mode |
| engResult | input | 8 | Result lines from the conversion engine |
| engDone | input | 1 | Engine end-of-conversion strobe |
| dataOut | output | 8 | Data bus value (0 when not driven) |
| dataOe | output | 1 | Data bus output enable |
| readyLow | output | 1 | 1 = drive the ready line low, 0 = release it |
| intN | output | 1 | Active-low conversion-complete interrupt |
| sampleStrobe | output | 1 | End-of-tracking pulse to the engine |
| selChan | output | 3 | Channel handed to the engine |
| spacingErr | output | 1 | One-cycle pulse for a rejected read |

## Verification
The bench builds the block with TRACK_CYC=4, COARSE_CYC=7 and SPACE_CYC=14. It runs an 8-channel build and a 4-channel build side by side. With windows this short, the bench can sweep every channel in both modes within a few hundred cycles. It can also place reads exactly 8, 12, 13 and 14 edges after an accepted start, so both sides of the spacing boundary and the busy rejection are exercised. The engine model changes the upper result nibble after the coarse point, which exposes any result that is not assembled in two steps.

// File: rtl/adc_bus_ctrl_pkg.sv
package adc_bus_ctrl_pkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic latchChan;   // capture the bus address as the converted channel
    logic latchUpper;  // capture the coarse half of the result
    logic loadResult;  // capture the fine half and publish the result
  } ctlStrobe_t;

endpackage

// File: rtl/adc_bus_ctrl_seq.sv
module adc_bus_ctrl_seq
  import adc_bus_ctrl_pkg::*;
#(
  parameter int TRACK_CYC  = 50,
  parameter int COARSE_CYC = 90,
  parameter int SPACE_CYC  = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       pipeMode,
  input  logic       engDone,
  output ctlStrobe_t strobe,
  output logic       sampleStrobe,
  output logic       dataOe,
  output logic       readyLow,
  output logic       intN,
  output logic       spacingErr
);

  localparam int CNT_W = $clog2(SPACE_CYC + 1);
  localparam logic [CNT_W-1:0] SPACE_V  = CNT_W'(SPACE_CYC);
  localparam logic [CNT_W-1:0] TRACK_V  = CNT_W'(TRACK_CYC);
  localparam logic [CNT_W-1:0] COARSE_V = CNT_W'(COARSE_CYC);

  logic csQ, rdQ;
  logic [CNT_W-1:0] sinceStart;
  logic busy, readyQ, intQ, fresh, accRead, errQ;

  logic active, activeQ, startReq, startOk, startBad;
  logic csFall, csRise, rdRise, readEnd, convDone;

  // Bus edge detection on the sampled strobes
  always_comb begin
    active   = !csN && !rdN;
    activeQ  = !csQ && !rdQ;
    startReq = active && !activeQ;
    startOk  = startReq && !busy && (sinceStart >= SPACE_V);
    startBad = startReq && !startOk;
    csFall   = csQ && !csN;
    csRise   = !csQ && csN;
    rdRise   = !rdQ && rdN;
    readEnd  = csRise || rdRise;
    convDone = busy && engDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= 1'b1;
      rdQ <= 1'b1;
    end else begin
      csQ <= csN;
      rdQ <= rdN;
    end
  end

  // Start-relative cycle counter: drives the tracking window, the coarse
  // point and the minimum spacing. It saturates once spacing is met.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceStart <= SPACE_V;
    end else if (startOk) begin
      sinceStart <= CNT_W'(1);
    end else if (sinceStart < SPACE_V) begin
      sinceStart <= sinceStart + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (startOk) begin
      busy <= 1'b1;
    end else if (convDone) begin
      busy <= 1'b0;
    end
  end

  // The read that started the current conversion is still open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRead <= 1'b0;
    end else if (startOk) begin
      accRead <= 1'b1;
    end else if (readEnd) begin
      accRead <= 1'b0;
    end
  end

  // Ready hold in stalling mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else if (convDone || startBad || csRise || pipeMode) begin
      readyQ <= 1'b0;
    end else if (csFall) begin
      readyQ <= 1'b1;
    end
  end

  // Interrupt: done has priority over the end of a read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intQ <= 1'b1;
    end else if (convDone) begin
      intQ <= 1'b0;
    end else if (readEnd && accRead) begin
      intQ <= 1'b1;
    end
  end

  // Fresh-result flag for the stalling read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fresh <= 1'b0;
    end else if (readEnd || startReq) begin
      fresh <= 1'b0;
    end else if (convDone && !pipeMode) begin
      fresh <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else begin
      errQ <= startBad;
    end
  end

  always_comb begin
    strobe.latchChan  = (startOk && !pipeMode) || (rdRise && accRead && pipeMode);
    strobe.latchUpper = busy && (sinceStart == COARSE_V);
    strobe.loadResult = convDone;
    sampleStrobe      = busy && (sinceStart == TRACK_V);
    dataOe            = active && (pipeMode || fresh);
    readyLow          = readyQ && !pipeMode;
    intN              = intQ;
    spacingErr        = errQ;
  end

  // R3: the bus is never driven in stalling mode while ready still holds
  assert_no_drive_while_stalled_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && dataOe) |-> !readyLow);

  // R4: interrupt falls only one cycle after an engine done during a conversion
  assert_int_fall_on_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && $past(intN)) |-> $past(engDone && busy));

  // R6: the sample strobe is a single-cycle pulse
  assert_single_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R8: a read opening during a conversion is always flagged
  assert_busy_start_flagged_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> spacingErr);

  // R5: pipelined mode never holds the ready line
  assert_no_ready_pipelined_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(pipeMode)) |-> !readyLow);

endmodule

// File: rtl/adc_bus_ctrl_path.sv
module adc_bus_ctrl_path
  import adc_bus_ctrl_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [2:0]       chanAddr,
  input  logic [RES_W-1:0] engResult,
  output logic [RES_W-1:0] resultQ,
  output logic [2:0]       selChan
);

  localparam int CH_W = (NUM_CH > 4) ? 3 : 2;
  localparam int HI_W = RES_W / 2;
  localparam int LO_W = RES_W - HI_W;

  logic [2:0]      chanMasked;
  logic [2:0]      chanQ;
  logic [HI_W-1:0] upperQ;

  // Address bits above the build's channel count are forced to zero
  for (genvar b = 0; b < 3; b++) begin : g_chanBit
    if (b < CH_W) begin : g_used
      assign chanMasked[b] = chanAddr[b];
    end else begin : g_unused
      assign chanMasked[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ <= '0;
    end else if (strobe.latchChan) begin
      chanQ <= chanMasked;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
    end else if (strobe.latchUpper) begin
      upperQ <= engResult[RES_W-1:LO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.loadResult) begin
      resultQ <= {upperQ, engResult[LO_W-1:0]};
    end
  end

  assign selChan = chanQ;

  // R1: an unused high address bit never reaches the engine
  assert_chan_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_CH <= 4) |-> !selChan[2]);

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_ctrl_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int TRACK_CYC  = 50,
  parameter int COARSE_CYC = 90,
  parameter int SPACE_CYC  = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic [2:0] chanAddr,
  input  logic       pipeMode,
  input  logic [7:0] engResult,
  input  logic       engDone,
  output logic [7:0] dataOut,
  output logic       dataOe,
  output logic       readyLow,
  output logic       intN,
  output logic       sampleStrobe,
  output logic [2:0] selChan,
  output logic       spacingErr
);

  ctlStrobe_t strobe;
  logic [7:0] resultQ;

  adc_bus_ctrl_seq #(
    .TRACK_CYC (TRACK_CYC),
    .COARSE_CYC(COARSE_CYC),
    .SPACE_CYC (SPACE_CYC)
  ) u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .csN         (csN),
    .rdN         (rdN),
    .pipeMode    (pipeMode),
    .engDone     (engDone),
    .strobe      (strobe),
    .sampleStrobe(sampleStrobe),
    .dataOe      (dataOe),
    .readyLow    (readyLow),
    .intN        (intN),
    .spacingErr  (spacingErr)
  );

  adc_bus_ctrl_path #(
    .NUM_CH(NUM_CH),
    .RES_W (8)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chanAddr (chanAddr),
    .engResult(engResult),
    .resultQ  (resultQ),
    .selChan  (selChan)
  );

  assign dataOut = dataOe ? resultQ : 8'h00;

endmodule

// File: tb/tb_adc_bus_ctrl.sv
module tb_adc_bus_ctrl;

  localparam int TRACK  = 4;
  localparam int COARSE = 7;
  localparam int SPACE  = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, pipeMode = 1'b0, engDone = 1'b0;
  logic [2:0] chanAddr = '0;
  logic [7:0] engResult = '0;
  logic [7:0] dataOut, dataOut4;
  logic dataOe, readyLow, intN, sampleStrobe, spacingErr;
  logic dataOe4, readyLow4, intN4, sampleStrobe4, spacingErr4;
  logic [2:0] selChan, selChan4;

  int tests = 0, fails = 0, expIdx = 0, stubIdx = 0, stubPhase = -1;
  logic [7:0] stubCode, lastDone, pend;

  always #10 clk = ~clk;

  adc_bus_ctrl #(.NUM_CH(8), .TRACK_CYC(TRACK), .COARSE_CYC(COARSE), .SPACE_CYC(SPACE)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .chanAddr(chanAddr), .pipeMode(pipeMode),
    .engResult(engResult), .engDone(engDone), .dataOut(dataOut), .dataOe(dataOe),
    .readyLow(readyLow), .intN(intN), .sampleStrobe(sampleStrobe), .selChan(selChan),
    .spacingErr(spacingErr));

  adc_bus_ctrl #(.NUM_CH(4), .TRACK_CYC(TRACK), .COARSE_CYC(COARSE), .SPACE_CYC(SPACE)) dut4 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .chanAddr(chanAddr), .pipeMode(pipeMode),
    .engResult(engResult), .engDone(engDone), .dataOut(dataOut4), .dataOe(dataOe4),
    .readyLow(readyLow4), .intN(intN4), .sampleStrobe(sampleStrobe4), .selChan(selChan4),
    .spacingErr(spacingErr4));

  function automatic logic [7:0] codeOf(input int ch, input int idx);
    return 8'((ch * 29 + idx * 53 + 17) % 256);
  endfunction

  // Engine model: upper nibble valid from the sample until after the coarse
  // point, then corrupted; lower nibble valid only with done.
  always @(negedge clk) begin
    if (sampleStrobe) begin
      stubCode  = codeOf(int'(selChan), stubIdx);
      stubIdx   = stubIdx + 1;
      stubPhase = 0;
      engResult = {stubCode[7:4], 4'h5};
    end else if (stubPhase >= 0) begin
      stubPhase = stubPhase + 1;
      if (stubPhase == 5) engResult[7:4] = ~stubCode[7:4];
      if (stubPhase == 6) begin
        engResult[3:0] = stubCode[3:0];
        engDone = 1'b1;
      end
      if (stubPhase == 7) begin
        engDone = 1'b0;
        engResult[3:0] = ~stubCode[3:0];
        stubPhase = -1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRead(input int ch);
    int sampIdx, nSamp, relIdx, oeEarly, errSeen;
    sampIdx = 0; nSamp = 0; relIdx = 0; oeEarly = 0; errSeen = 0;
    @(negedge clk);
    chanAddr = 3'(ch);
    csN = 1'b0;
    @(negedge clk);
    chk("R2 ready held after chip select", 32'(readyLow), 1);
    rdN = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (sampleStrobe) begin nSamp++; sampIdx = i; end
      if (spacingErr) errSeen = 1;
      if (!readyLow) begin relIdx = i; break; end
      if (dataOe) oeEarly = 1;
    end
    chk("R3 no drive before done", 32'(oeEarly), 0);
    chk("R3 ready released at done", 32'(relIdx), 11);
    chk("R6 sample position", 32'(sampIdx), TRACK);
    chk("R6 sample count", 32'(nSamp), 1);
    chk("R8 spaced start accepted", 32'(errSeen), 0);
    chk("R3 drive at done", 32'(dataOe), 1);
    chk("R7 result value", 32'(dataOut), 32'(codeOf(ch, expIdx)));
    chk("R4 int low at done", 32'(intN), 0);
    chk("R1 channel 8-ch build", 32'(selChan), 32'(ch));
    chk("R1 channel 4-ch build", 32'(selChan4), 32'(ch % 4));
    lastDone = codeOf(ch, expIdx);
    expIdx++;
    rdN = 1'b1;
    csN = 1'b1;
    @(negedge clk);
    chk("R4 int high after read end", 32'(intN), 1);
    chk("R3 bus released", 32'(dataOe), 0);
    chk("R3 bus zero when released", 32'(dataOut), 0);
  endtask

  task automatic pipeRead(input int ch, input bit acc, input logic [7:0] expData, input int expSel);
    @(negedge clk);
    chanAddr = 3'(ch);
    csN = 1'b0;
    rdN = 1'b0;
    @(negedge clk);
    chk("R5 immediate drive", 32'(dataOe), 1);
    chk("R5 previous result", 32'(dataOut), 32'(expData));
    chk("R5 ready unused", 32'(readyLow), 0);
    chk("R8 spacing flag", 32'(spacingErr), acc ? 0 : 1);
    rdN = 1'b1;
    csN = 1'b1;
    @(negedge clk);
    chk("R8 flag is one cycle", 32'(spacingErr), 0);
    chk("R5 address captured on read rise", 32'(selChan), 32'(expSel));
    if (acc) chk("R4 int high after accepted read", 32'(intN), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset int", 32'(intN), 1);
    chk("R9 reset ready", 32'(readyLow), 0);
    chk("R9 reset oe", 32'(dataOe), 0);
    chk("R9 reset err", 32'(spacingErr), 0);
    chk("R9 reset data", 32'(dataOut), 0);
    rstN = 1'b1;
    idle(2);
    chk("R9 idle int after reset", 32'(intN), 1);

    // Stalling mode over every channel; each read starts exactly SPACE edges after the last
    for (int ch = 0; ch < 8; ch++) waitRead(ch);
    idle(4);

    // Pipelined mode over every channel
    pipeMode = 1'b1;
    for (int ch = 0; ch < 8; ch++) begin
      pipeRead(ch, 1'b1, lastDone, ch);
      lastDone = codeOf(ch, expIdx);
      expIdx++;
      idle(12);
    end

    // Spacing and busy rejection
    pipeRead(3, 1'b1, lastDone, 3);
    pend = codeOf(3, expIdx); expIdx++;
    idle(5);
    pipeRead(5, 1'b0, lastDone, 3);       // attempt 8 edges after start: busy
    idle(1);
    chk("R4 int low after done", 32'(intN), 0);
    lastDone = pend;
    pipeRead(1, 1'b0, lastDone, 3);       // attempt 12 edges after start
    chk("R8 rejected read leaves int", 32'(intN), 0);
    pipeRead(6, 1'b1, lastDone, 6);       // attempt 15 edges after start
    pend = codeOf(6, expIdx); expIdx++;
    idle(11);
    pipeRead(0, 1'b1, pend, 0);           // exactly SPACE edges after start
    lastDone = codeOf(0, expIdx); expIdx++;
    idle(10);
    pipeRead(2, 1'b0, lastDone, 0);       // SPACE-1 edges after start
    pipeRead(4, 1'b1, lastDone, 4);       // result unchanged by the rejected read
    lastDone = codeOf(4, expIdx); expIdx++;
    idle(12);
    pipeRead(7, 1'b1, lastDone, 7);
    expIdx++;
    idle(12);

    // Back to stalling mode: fresh result, address bit 2 dropped in the 4-channel build
    pipeMode = 1'b0;
    idle(2);
    waitRead(5);
    idle(4);
    chk("R6 engine saw one sample per accepted read", 32'(stubIdx), 32'(expIdx));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule